// File: doc/BRIEF.md
# Triggered Capture Buffer with Holdoff

This block is a small logic-analyzer capture engine. On every data-clock cycle where the clock enable is high, it writes one sample word into a circular memory of `2**LGMEMLEN` words. Once it has filled the whole memory, it waits for a trigger. After the trigger it keeps recording for a programmable number of further samples and then freezes. At that point the memory holds a window of history around the trigger event.

A trigger comes either from an external input or from a manual request bit. A disable bit masks only the external trigger. When capture completes, the block raises an interrupt level, and the disable bit gates that level. The write pointer is held frozen after the stop, so it names the oldest sample in the buffer. A combinational read port lets the surrounding logic drain the memory from that address onward.

The controller has four states. RUN fills the memory. ARMED waits for a trigger. HOLD counts out the holdoff. DONE is frozen. The transitions are:
- RUN to ARMED, on the write to the last address.
- ARMED to HOLD, on a trigger with a non-zero holdoff.
- ARMED to DONE, on a trigger with a zero holdoff.
- HOLD to DONE, on the last holdoff sample.
- Any state to RUN, on the restart strobe or on the reset.

Top module: `trig_capture_buf`

## Requirements
- R1: The asynchronous reset (`rst_n` low) or a `cmd_restart` pulse puts the block in RUN with all three status flags low, `wr_ptr` at 0 and `irq` low. On a restart cycle no sample is written, even if `ce` and a trigger are high in that cycle.
- R2: Outside DONE, every cycle with `ce` high writes `sample_in` to the address `wr_ptr`, and `wr_ptr` then advances by one modulo the depth. A cycle with `ce` low writes nothing and leaves `wr_ptr` unchanged.
- R3: `primed` rises after the clock edge of the cycle that writes address `DEPTH-1` in RUN. A trigger in RUN has no effect, including a trigger in that completing cycle.
- R4: An external trigger is taken only while `primed` is high and `ce` is high. A single-cycle pulse is enough.
- R5: After the trigger sample, exactly `cfg_holdoff` further enabled samples are written, and then `stopped` rises. In DONE, nothing is written and `wr_ptr` stays fixed.
- R6: With a holdoff of 0, the trigger sample is at `wr_ptr-1`, the newest entry. With a holdoff of `DEPTH-1`, it is at `wr_ptr`, the oldest entry.
- R7: While `cfg_manual` is high, the first enabled cycle in ARMED triggers. If `cfg_manual` is held through a restart, the trigger waits for the refill to reach ARMED.
- R8: While `cfg_disable` is high, the external trigger is ignored. Recording, priming and manual triggering carry on as normal.
- R9: `irq` is high exactly when `stopped` is high and `cfg_disable` is low. If disable is set after the trigger, the block still reaches DONE, but `irq` stays low until disable clears.
- R10: The flags `triggered` and `stopped` are sticky until the next reset or restart. `triggered` implies `primed`, and `stopped` implies `triggered`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; one sample per high cycle |
| trig_in | input | 1 | External trigger, active high |
| sample_in | input | DATA_W | Sample word to record |
| cfg_holdoff | input | HOLD_W | Samples kept after the trigger |
| cfg_manual | input | 1 | Manual trigger request (level) |
| cfg_disable | input | 1 | Masks the external trigger and the interrupt |
| cmd_restart | input | 1 | Synchronous restart strobe |
| rd_addr | input | LGMEMLEN | Read address of the capture memory |
| rd_data | output | DATA_W | Memory word at `rd_addr` |
| primed | output | 1 | Memory filled since the last restart |
| triggered | output | 1 | Trigger recognised |
| stopped | output | 1 | Capture complete, buffer frozen |
| wr_ptr | output | LGMEMLEN | Next write address; the oldest sample once stopped |
| irq | output | 1 | Completion interrupt level |

## Verification
Two pairs of events can land in the same cycle. The first pair is a restart strobe arriving together with an enabled sample and a trigger. The bench provokes this and expects the restart to win: no write, a pointer of zero and cleared flags. The second pair is a trigger arriving in the very cycle that completes the fill. Here the fill must win, so `primed` rises while `triggered` stays low. Random phases drive `ce`, the trigger, the manual and disable bits and restarts together from a fixed seed. Every cycle is compared against a bench-side model of the requirements, and the model's memory image is compared with the frozen buffer after each stop.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_t;
endpackage

// File: rtl/cap_mem.sv
module cap_mem #(
    parameter int DATA_W   = 32,
    parameter int LGMEMLEN = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [LGMEMLEN-1:0] rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [LGMEMLEN-1:0] ptr,
    output logic                ptr_last
);
    localparam int DEPTH = 1 << LGMEMLEN;
    localparam logic [LGMEMLEN-1:0] LAST_ADDR = LGMEMLEN'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            store[ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (restart)
            ptr <= '0;
        else if (wr_en)
            ptr <= ptr + 1'b1;
    end

    assign ptr_last = (ptr == LAST_ADDR);
    assign rd_data  = store[rd_addr];
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
    import cap_pkg::*;
#(
    parameter int HOLD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              trig_in,
    input  logic [HOLD_W-1:0] holdoff,
    input  logic              manual,
    input  logic              dis,
    input  logic              restart,
    input  logic              ptr_last,
    output logic              wr_en,
    output logic              primed,
    output logic              triggered,
    output logic              stopped,
    output logic              irq
);
    cap_state_t        state_q, state_d;
    logic [HOLD_W-1:0] cnt_q, cnt_d;
    logic              hit;

    assign hit = manual | (trig_in & ~dis);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart) begin
            state_d = ST_RUN;
            cnt_d   = '0;
        end else if (ce) begin
            unique case (state_q)
                ST_RUN: begin
                    if (ptr_last)
                        state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (hit) begin
                        if (holdoff == '0) begin
                            state_d = ST_DONE;
                        end else begin
                            state_d = ST_HOLD;
                            cnt_d   = holdoff;
                        end
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == HOLD_W'(1))
                        state_d = ST_DONE;
                    cnt_d = cnt_q - 1'b1;
                end
                ST_DONE: begin
                    state_d = ST_DONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        wr_en     = 1'b0;
        primed    = 1'b0;
        triggered = 1'b0;
        stopped   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                wr_en = ce & ~restart;
            end
            ST_ARMED: begin
                wr_en  = ce & ~restart;
                primed = 1'b1;
            end
            ST_HOLD: begin
                wr_en     = ce & ~restart;
                primed    = 1'b1;
                triggered = 1'b1;
            end
            ST_DONE: begin
                primed    = 1'b1;
                triggered = 1'b1;
                stopped   = 1'b1;
            end
        endcase
        irq = stopped & ~dis;
    end
endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf #(
    parameter int DATA_W   = 32,
    parameter int LGMEMLEN = 5,
    parameter int HOLD_W   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  logic                trig_in,
    input  logic [DATA_W-1:0]   sample_in,
    input  logic [HOLD_W-1:0]   cfg_holdoff,
    input  logic                cfg_manual,
    input  logic                cfg_disable,
    input  logic                cmd_restart,
    input  logic [LGMEMLEN-1:0] rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                primed,
    output logic                triggered,
    output logic                stopped,
    output logic [LGMEMLEN-1:0] wr_ptr,
    output logic                irq
);
    logic wr_en;
    logic ptr_last;

    cap_fsm #(.HOLD_W(HOLD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .trig_in   (trig_in),
        .holdoff   (cfg_holdoff),
        .manual    (cfg_manual),
        .dis       (cfg_disable),
        .restart   (cmd_restart),
        .ptr_last  (ptr_last),
        .wr_en     (wr_en),
        .primed    (primed),
        .triggered (triggered),
        .stopped   (stopped),
        .irq       (irq)
    );

    cap_mem #(.DATA_W(DATA_W), .LGMEMLEN(LGMEMLEN)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cmd_restart),
        .wr_en    (wr_en),
        .wr_data  (sample_in),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ptr      (wr_ptr),
        .ptr_last (ptr_last)
    );
endmodule

// File: rtl/trig_capture_buf_chk.sv
module trig_capture_buf_chk #(
    parameter int LGMEMLEN = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ce,
    input logic                cmd_restart,
    input logic                primed,
    input logic                triggered,
    input logic                stopped,
    input logic                irq,
    input logic [LGMEMLEN-1:0] wr_ptr
);
    // R1
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_restart |=> (wr_ptr == '0 && !primed && !triggered && !stopped));

    // R2
    no_ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !cmd_restart) |=> $stable(wr_ptr));

    // R5
    frozen_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !cmd_restart) |=> $stable(wr_ptr));

    // R4
    trig_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> ($past(ce) && $past(primed)));

    // R9
    irq_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stopped);

    // R10
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!triggered || primed) && (!stopped || triggered));

    // R10
    sticky_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !cmd_restart) |=> triggered);
endmodule

bind trig_capture_buf trig_capture_buf_chk #(.LGMEMLEN(LGMEMLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce          (ce),
    .cmd_restart (cmd_restart),
    .primed      (primed),
    .triggered   (triggered),
    .stopped     (stopped),
    .irq         (irq),
    .wr_ptr      (wr_ptr)
);

// File: tb/tb_trig_capture_buf.sv
module tb_trig_capture_buf;
    localparam int DW    = 32;
    localparam int LG    = 5;
    localparam int HW    = 20;
    localparam int DEPTH = 1 << LG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0, trig_in = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic [HW-1:0] cfg_holdoff = '0;
    logic          cfg_manual = 1'b0, cfg_disable = 1'b0, cmd_restart = 1'b0;
    logic [LG-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          primed, triggered, stopped, irq;
    logic [LG-1:0] wr_ptr;

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench model (0 run, 1 armed, 2 hold, 3 done)
    int            m_st = 0;
    logic [LG-1:0] m_ptr = '0;
    int            m_cnt = 0;
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] trig_word;
    logic [LG-1:0] trig_addr;

    always #2 clk = ~clk;

    trig_capture_buf #(.DATA_W(DW), .LGMEMLEN(LG), .HOLD_W(HW)) dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_flags();
        logic p = (m_st >= 1), t = (m_st >= 2), s = (m_st == 3);
        return {p, t, s, s & ~cfg_disable};
    endfunction

    task automatic model_edge();
        if (cmd_restart) begin
            m_st = 0; m_ptr = '0; m_cnt = 0;
        end else if (ce && m_st != 3) begin
            m_mem[m_ptr] = sample_in;
            case (m_st)
                0: if (m_ptr == LG'(DEPTH-1)) m_st = 1;
                1: if (cfg_manual || (trig_in && !cfg_disable)) begin
                       trig_word = sample_in; trig_addr = m_ptr;
                       if (cfg_holdoff == 0) m_st = 3;
                       else begin m_st = 2; m_cnt = int'(cfg_holdoff); end
                   end
                2: begin if (m_cnt == 1) m_st = 3; m_cnt--; end
                default: ;
            endcase
            m_ptr = m_ptr + 1'b1;
        end
    endtask

    // drive at negedge, clock, compare at next negedge
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({req, " flags"}, {60'd0, primed, triggered, stopped, irq}, {60'd0, exp_flags()});
        chk({req, " wr_ptr"}, 64'(wr_ptr), 64'(m_ptr));
    endtask

    task automatic read_chk(input string req, input logic [LG-1:0] a, input logic [DW-1:0] e);
        rd_addr = a;
        #1;
        chk(req, 64'(rd_data), 64'(e));
    endtask

    task automatic restart(input int hold, input bit man, input bit dis);
        cfg_holdoff = HW'(hold); cfg_manual = man; cfg_disable = dis;
        cmd_restart = 1'b1; ce = 1'b0; trig_in = 1'b0;
        step("R1 restart");
        cmd_restart = 1'b0;
    endtask

    task automatic fill(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            ce = 1'b1; sample_in = $urandom; trig_in = 1'b0;
            step(req);
        end
    endtask

    task automatic dump(input string req);
        for (int i = 0; i < DEPTH; i++) read_chk(req, LG'(i), m_mem[i]);
    endtask

    initial begin
        void'($urandom(32'd7713));
        #1;
        chk("R1 reset flags", {60'd0, primed, triggered, stopped, irq}, 64'd0);
        chk("R1 reset ptr", 64'(wr_ptr), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // A: holdoff 0, trigger on completing fill cycle ignored (R3)
        restart(0, 0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            ce = 1'b1; sample_in = 32'h1000 + i; trig_in = (i == DEPTH-1);
            step("R3 fill");
        end
        chk("R3 primed no trig", {62'd0, primed, triggered}, 64'b10);
        ce = 1'b0; trig_in = 1'b1; step("R4 ce low");
        chk("R4 no trig without ce", 64'(triggered), 64'd0);
        ce = 1'b1; trig_in = 1'b1; sample_in = 32'hABCD0000; step("R4 pulse");
        trig_in = 1'b0;
        chk("R5 stop at holdoff 0", 64'(stopped), 64'd1);
        read_chk("R6 newest is trigger", wr_ptr - 1'b1, 32'hABCD0000);
        for (int i = 0; i < 5; i++) begin ce = 1'b1; sample_in = $urandom; step("R5 frozen"); end
        dump("R5 buffer frozen");

        // B: holdoff DEPTH-1, trigger ends oldest (R6)
        restart(DEPTH-1, 0, 0);
        fill("R2 fill");
        ce = 1'b1; trig_in = 1'b1; sample_in = 32'h5EED5EED; step("R4 trig");
        trig_in = 1'b0;
        for (int i = 0; i < DEPTH-1; i++) begin
            ce = (i % 3 != 1); sample_in = $urandom; step("R5 holdoff");
            if (i % 3 == 1) chk("R2 ce low", 64'(wr_ptr), 64'(m_ptr));
        end
        while (!stopped) begin ce = 1'b1; sample_in = $urandom; step("R5 finish"); end
        read_chk("R6 oldest is trigger", wr_ptr, 32'h5EED5EED);
        chk("R9 irq", 64'(irq), 64'd1);

        // C: manual held through restart, disable masks external (R7, R8)
        restart(3, 1, 1);
        ce = 1'b1; trig_in = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin sample_in = $urandom; step("R7 refill"); end
        chk("R7 waits for prime", 64'(triggered), 64'd0);
        cfg_manual = 1'b0; sample_in = $urandom; step("R8 disabled ext");
        chk("R8 ext ignored", 64'(triggered), 64'd0);
        chk("R8 still recording", 64'(wr_ptr), 64'd1);
        cfg_manual = 1'b1; step("R7 manual");
        chk("R7 manual trig", 64'(triggered), 64'd1);
        cfg_manual = 1'b0;
        for (int i = 0; i < 3; i++) begin sample_in = $urandom; step("R9 hold"); end
        chk("R9 stopped while disabled", 64'(stopped), 64'd1);
        chk("R9 irq masked", 64'(irq), 64'd0);
        cfg_disable = 1'b0; #1;
        chk("R9 irq after enable", 64'(irq), 64'd1);

        // D: restart colliding with ce and trigger (R1)
        cmd_restart = 1'b1; ce = 1'b1; trig_in = 1'b1; cfg_manual = 1'b1;
        step("R1 collide");
        cmd_restart = 1'b0; cfg_manual = 1'b0; trig_in = 1'b0;
        chk("R1 restart wins", 64'(wr_ptr), 64'd0);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            cmd_restart = ($urandom_range(0, 299) == 0);
            if (cmd_restart) begin
                cfg_holdoff = HW'($urandom_range(0, 40));
                cfg_manual  = ($urandom_range(0, 3) == 0);
            end
            if ($urandom_range(0, 99) == 0) cfg_disable = ~cfg_disable;
            ce = ($urandom_range(0, 3) != 0);
            trig_in = ($urandom_range(0, 19) == 0);
            sample_in = $urandom;
            step("R10 random");
            if (m_st == 3 && $urandom_range(0, 49) == 0) dump("R2 random dump");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule